// File: doc/BRIEF.md
# Conversion clock divider with periodic queue triggers

This block paces a successive-approximation converter from the system clock. A software-written divide field sets how often a one-cycle conversion-clock enable appears. The enable is a pulse in the system clock domain and is not a derived clock. A field value of zero selects divide-by-two. Any other value v selects divide-by-(v+1), and the divisor never goes above forty.

A free-running binary counter advances once per conversion-clock enable. Each of two conversion queues has its own rate select, which picks one counter bit between bit 7 and bit 17. Each time the bits below the chosen bit carry into it, that queue receives a one-cycle trigger pulse, so the queue can start periodic or interval scans.

The divide field may only change while both queues are disabled. A write attempted while either queue is enabled is dropped, and a sticky error flag is raised.

Top module: `adc_clk_gen`

## Requirements
- R1: With a divide field value v in 1..39, `conv_tick` pulses exactly once every v+1 system clock cycles.
- R2: With a divide field value of 0, `conv_tick` pulses once every 2 cycles.
- R3: A divide field value of 40..63 behaves as divide-by-40.
- R4: A divide write (`presc_we` high) in a cycle where any bit of `q_enabled` is high leaves the divisor unchanged and sets `presc_err` to 1. `presc_err` stays 1 until reset.
- R5: `conv_tick` is high for one cycle at a time and is never high in two consecutive cycles.
- R6: The periodic counter advances by one only on a `conv_tick` cycle. A rate select r in 1..11 makes that queue's bit of `trig` pulse for one cycle once every 2^(6+r) ticks.
- R7: A rate select of 0, or any value 12..15, produces no trigger pulses for that queue.
- R8: A rate write (`rate_we[i]` high loads `rate_wdata` into queue i, with bit 0 for queue 1 and bit 1 for queue 2) is accepted whether or not the queues are enabled. The two queues run independently.
- R9: Reset sets the divide field to 0 (divide-by-2), clears `presc_err`, the divider, the periodic counter and the rate selects, and holds `trig` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_we | input | 1 | Divide field write strobe |
| presc_wdata | input | 6 | Divide field write value |
| rate_we | input | 2 | Per-queue rate select write strobes |
| rate_wdata | input | 4 | Rate select write value |
| q_enabled | input | 2 | Queue enabled status, one bit per queue |
| conv_tick | output | 1 | One-cycle conversion-clock enable |
| trig | output | 2 | One-cycle periodic trigger per queue |
| presc_err | output | 1 | Sticky rejected-write flag |

## Verification
The assertions rely on the queue-enable inputs being sampled on the same edge as the divide write. In other words, "enabled" means enabled in the cycle where the strobe is high, and the bench changes `q_enabled` only at falling edges away from any write. The assertions also assume that rate selects change only through the write strobe. The stimulus therefore writes rates while triggers run, but it measures trigger spacing only after at least one full period has passed since the last write. Long taps are covered only by the bound assertions, because they would need hundreds of thousands of cycles. The bench exercises the two shortest taps at several divisors.

// File: rtl/adcclk_pkg.sv
package adcclk_pkg;
    localparam int PRESC_W  = 6;
    localparam int DIV_MAX  = 40;
    localparam int TAP_LO   = 7;
    localparam int TAP_HI   = 17;
    localparam int SEL_W    = 4;
    localparam int NQ       = 2;
    localparam int NUM_RATES = TAP_HI - TAP_LO + 1;
    localparam int CTR_W    = TAP_HI;
    localparam int DIV_W    = $clog2(DIV_MAX + 1);
endpackage

// File: rtl/adcclk_prescaler.sv
module adcclk_prescaler #(
    parameter int PRESC_W = adcclk_pkg::PRESC_W,
    parameter int DIV_MAX = adcclk_pkg::DIV_MAX,
    parameter int NQ      = adcclk_pkg::NQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               presc_we,
    input  logic [PRESC_W-1:0] presc_wdata,
    input  logic [NQ-1:0]      q_enabled,
    output logic               tick,
    output logic               err
);
    localparam int DIV_W = $clog2(DIV_MAX + 1);

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [DIV_W-1:0]   cnt;
        logic               tick;
        logic               err;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [DIV_W-1:0] div_n;
    logic             wr_block;

    function automatic logic [DIV_W-1:0] divisor_of(input logic [PRESC_W-1:0] p);
        if (p == '0)
            return DIV_W'(2);
        else if (int'(p) >= DIV_MAX - 1)
            return DIV_W'(DIV_MAX);
        else
            return DIV_W'(int'(p) + 1);
    endfunction

    always_comb begin
        s_d      = s_q;
        div_n    = divisor_of(s_q.presc);
        wr_block = |q_enabled;
        s_d.tick = (s_q.cnt == div_n - DIV_W'(1));
        s_d.cnt  = s_d.tick ? '0 : s_q.cnt + DIV_W'(1);
        if (presc_we) begin
            if (wr_block) begin
                s_d.err = 1'b1;
            end else begin
                s_d.presc = presc_wdata;
                s_d.cnt   = '0;
                s_d.tick  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = s_q.tick;
    assign err  = s_q.err;

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.tick |=> !s_q.tick);
    // R4
    presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|q_enabled) |=> $stable(s_q.presc));
    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(s_q.err));
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.cnt) < DIV_MAX);
endmodule

// File: rtl/adcclk_interval_ctr.sv
module adcclk_interval_ctr #(
    parameter int CTR_W = adcclk_pkg::CTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CTR_W-1:0] ctr
);
    typedef struct packed {
        logic [CTR_W-1:0] ctr;
    } ctr_state_t;

    ctr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) s_d.ctr = s_q.ctr + CTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctr = s_q.ctr;

    // R6
    ctr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.ctr));
endmodule

// File: rtl/adcclk_trig_tap.sv
module adcclk_trig_tap #(
    parameter int SEL_W  = adcclk_pkg::SEL_W,
    parameter int TAP_LO = adcclk_pkg::TAP_LO,
    parameter int TAP_HI = adcclk_pkg::TAP_HI,
    parameter int CTR_W  = adcclk_pkg::CTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rate_we,
    input  logic [SEL_W-1:0] rate_wdata,
    input  logic             tick,
    input  logic [CTR_W-1:0] ctr,
    output logic             trig
);
    localparam int NUM_RATES = TAP_HI - TAP_LO + 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             trig;
    } tap_state_t;

    tap_state_t s_d, s_q;
    logic       rate_ok;
    logic       carry;
    int         tap;

    always_comb begin
        s_d     = s_q;
        if (rate_we) s_d.sel = rate_wdata;
        rate_ok = (s_q.sel != '0) && (int'(s_q.sel) <= NUM_RATES);
        tap     = int'(s_q.sel) + TAP_LO - 1;
        carry   = 1'b1;
        for (int i = 0; i < CTR_W; i++) begin
            if (i < tap && !ctr[i]) carry = 1'b0;
        end
        s_d.trig = tick && rate_ok && carry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign trig = s_q.trig;

    // R6
    trig_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig |-> $past(tick));
    // R6
    trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.trig |=> !s_q.trig);
endmodule

// File: rtl/adc_clk_gen.sv
module adc_clk_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       presc_we,
    input  logic [5:0] presc_wdata,
    input  logic [1:0] rate_we,
    input  logic [3:0] rate_wdata,
    input  logic [1:0] q_enabled,
    output logic       conv_tick,
    output logic [1:0] trig,
    output logic       presc_err
);
    import adcclk_pkg::*;

    logic             tick_w;
    logic [CTR_W-1:0] ctr_w;

    adcclk_prescaler #(.PRESC_W(PRESC_W), .DIV_MAX(DIV_MAX), .NQ(NQ)) u_pre (
        .clk(clk), .rst_n(rst_n), .presc_we(presc_we), .presc_wdata(presc_wdata),
        .q_enabled(q_enabled), .tick(tick_w), .err(presc_err)
    );

    adcclk_interval_ctr #(.CTR_W(CTR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .ctr(ctr_w)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        adcclk_trig_tap #(.SEL_W(SEL_W), .TAP_LO(TAP_LO), .TAP_HI(TAP_HI), .CTR_W(CTR_W)) u_tap (
            .clk(clk), .rst_n(rst_n), .rate_we(rate_we[q]), .rate_wdata(rate_wdata),
            .tick(tick_w), .ctr(ctr_w), .trig(trig[q])
        );
    end

    assign conv_tick = tick_w;

    // R9
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (trig == '0 && !presc_err));
endmodule

// File: tb/tb_adc_clk_gen.sv
module tb_adc_clk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_we = 1'b0;
    logic [5:0] presc_wdata = '0;
    logic [1:0] rate_we = '0;
    logic [3:0] rate_wdata = '0;
    logic [1:0] q_enabled = '0;
    logic       conv_tick;
    logic [1:0] trig;
    logic       presc_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    adc_clk_gen dut (
        .clk(clk), .rst_n(rst_n), .presc_we(presc_we), .presc_wdata(presc_wdata),
        .rate_we(rate_we), .rate_wdata(rate_wdata), .q_enabled(q_enabled),
        .conv_tick(conv_tick), .trig(trig), .presc_err(presc_err)
    );

    localparam int NV = 8;
    localparam int PV [NV] = '{0, 1, 2, 5, 9, 39, 40, 63};
    localparam int EV [NV] = '{2, 2, 3, 6, 10, 40, 40, 40};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int w);
        return (w == 0) ? conv_tick : trig[w-1];
    endfunction

    task automatic period(input int w, output int p);
        p = 0;
        do @(negedge clk); while (!pick(w));
        do begin @(negedge clk); p++; end while (!pick(w));
    endtask

    task automatic wr_presc(input int v);
        @(negedge clk); presc_we = 1'b1; presc_wdata = 6'(v);
        @(negedge clk); presc_we = 1'b0;
    endtask

    task automatic wr_rate(input int q, input int v);
        @(negedge clk); rate_we = 2'(1 << q); rate_wdata = 4'(v);
        @(negedge clk); rate_we = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int p, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(presc_err == 1'b0, "R9 err after reset", int'(presc_err), 0);
        chk(trig == 2'b00, "R9 trig after reset", int'(trig), 0);
        period(0, p);
        chk(p == 2, "R9 default divisor", p, 2);

        // R1 R2 R3: divisor table
        for (int i = 0; i < NV; i++) begin
            wr_presc(PV[i]);
            period(0, p);
            period(0, p);
            chk(p == EV[i], $sformatf("R1/R2/R3 presc=%0d", PV[i]), p, EV[i]);
        end

        // R5: never two consecutive ticks at divide-by-2
        wr_presc(0);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (conv_tick && i > 4) cnt++;
        end
        chk(cnt == 17 || cnt == 18, "R5 tick density", cnt, 18);

        // R4: write while enabled is ignored
        wr_presc(4);
        @(negedge clk); q_enabled = 2'b10;
        wr_presc(20);
        chk(presc_err == 1'b1, "R4 err set", int'(presc_err), 1);
        period(0, p); period(0, p);
        chk(p == 5, "R4 divisor kept", p, 5);
        @(negedge clk); q_enabled = 2'b00;
        @(negedge clk);
        chk(presc_err == 1'b1, "R4 err sticky", int'(presc_err), 1);
        wr_presc(0);
        period(0, p); period(0, p);
        chk(p == 2, "R4 write accepted when idle", p, 2);

        // R6 R8: triggers, rates written while enabled
        @(negedge clk); q_enabled = 2'b11;
        wr_rate(0, 1);
        wr_rate(1, 2);
        period(1, p); period(1, p);
        chk(p == 256, "R6 q1 rate1 div2", p, 256);
        period(2, p); period(2, p);
        chk(p == 512, "R8 q2 rate2 div2", p, 512);
        do @(negedge clk); while (!trig[0]);
        cnt = 0;
        do begin @(negedge clk); if (conv_tick) cnt++; end while (!trig[0]);
        chk(cnt == 128, "R6 ticks per trigger", cnt, 128);

        @(negedge clk); q_enabled = 2'b00;
        wr_presc(2);
        period(1, p); period(1, p);
        chk(p == 384, "R6 q1 rate1 div3", p, 384);

        // R7: rate 0 and out-of-range rate silence the queue
        wr_rate(0, 0);
        cnt = 0;
        for (int i = 0; i < 1000; i++) begin @(negedge clk); if (trig[0]) cnt++; end
        chk(cnt == 0, "R7 rate 0 silent", cnt, 0);
        wr_rate(0, 13);
        cnt = 0;
        for (int i = 0; i < 1000; i++) begin @(negedge clk); if (trig[0]) cnt++; end
        chk(cnt == 0, "R7 rate 13 silent", cnt, 0);
        period(2, p); period(2, p);
        chk(p == 768, "R8 q2 unaffected", p, 768);

        // R9: reset clears the sticky error and divisor
        do_reset();
        @(negedge clk);
        chk(presc_err == 1'b0, "R9 err cleared", int'(presc_err), 0);
        period(0, p);
        chk(p == 2, "R9 divisor back to 2", p, 2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule